// File: doc/BRIEF.md
# Serial Control Register Bank

This block takes 32-bit control words from a slow three-wire serial link and places each word into one of three internal control registers. The three wires are a shift clock, a data line and a latch strobe. The link runs on its own and is not tied to the system clock. All three wires are brought into the system clock domain through two-flop synchronisers. Edges of the shift clock and the strobe are then found by comparing successive synchronised samples.

A word is shifted in least significant bit first. On the strobe's rising edge, the four low bits of the word choose which register receives it. The bank holds a setup register, a calibration register and a divider register.

Two control bits clear themselves:
- The calibration-start bit clears when the calibration engine reports it is done.
- The divider-load bit clears when the loop reports lock.

While a calibration is running, the calibration and divider registers refuse new words. A flag that a power-up calibration is still owed is reported in the top bit of the setup register. The block also provides the divider fields that the dividers actually use, and the resolved output-buffer enable.

Top module: `serial_ctl_regs`

## Requirements
- R1: Serial data is sampled on each rising edge of the shift clock into a 32-bit shift register, least significant bit first. After 32 shift edges the first bit sent is bit 0. On a rising strobe edge the whole word, address bits included, is copied into the selected register.
- R2: Address code 0 in bits 3:0 selects the setup register, code 1 the calibration register and code 2 the divider register. A word carrying any other address code changes no register.
- R3: A setup word with bit 4 set is not stored. Instead it clears setup bits 30:0, the calibration register, the divider register and the applied divider fields to zero.
- R4: Calibration register bit 31 (busy) stays set after it is written as 1. It clears on the first cycle that `cal_done` is high, and no other bit of that register changes.
- R5: While calibration register bit 31 is set, words addressed to the calibration or divider register are discarded. Setup words are still accepted.
- R6: The applied divider fields `div_live` follow divider register bits 24:4 only while divider register bit 29 (load request) is set. A divider word with bit 29 clear leaves `div_live` unchanged.
- R7: `lock_ok` clears divider register bit 29 when it is set and leaves every other bit unchanged. `lock_ok` with no load request pending has no effect.
- R8: When setup bit 10 is 0, `buf_en` is the inverse of setup bit 11. When setup bit 10 is 1, `buf_en` follows the `buf_pin` input.
- R9: Setup register bit 31 reads 1 after hardware reset. It drops to 0 when `cal_done` arrives during a calibration. Serial writes never change it, and neither does the bit-4 clear.
- R10: After hardware reset, setup reads 0x80000000. The calibration register, the divider register and `div_live` read 0, and `buf_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_strobe | input | 1 | Serial latch strobe, asynchronous |
| cal_done | input | 1 | Calibration engine finished |
| lock_ok | input | 1 | Loop reports lock |
| buf_pin | input | 1 | External output-buffer enable |
| setup_reg | output | 32 | Setup register; bit 31 is the calibration-owed flag |
| cal_reg | output | 32 | Calibration register |
| div_reg | output | 32 | Divider register |
| div_live | output | 21 | Divider fields in use by the dividers |
| buf_en | output | 1 | Resolved output-buffer enable |

## Verification
If a bit is lost or misaligned in the shift path, the register that a word addresses shows the wrong value six system cycles after the strobe rises. If a self-clearing bit sticks, the handshake input leaves it set one cycle later. If a lockout is missing, a divider or calibration word sent during a calibration appears in its register as soon as that word is committed. A stale load request shows in `div_live`, which tracks any divider word while bit 29 stays set.

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs #(
  parameter int WORD_W = 32,
  parameter int LIVE_LO = 4,
  parameter int LIVE_HI = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_data,
  input  logic                       ser_strobe,
  input  logic                       cal_done,
  input  logic                       lock_ok,
  input  logic                       buf_pin,
  output logic [WORD_W-1:0]          setup_reg,
  output logic [WORD_W-1:0]          cal_reg,
  output logic [WORD_W-1:0]          div_reg,
  output logic [LIVE_HI-LIVE_LO:0]   div_live,
  output logic                       buf_en
);
  localparam int LIVE_W = LIVE_HI - LIVE_LO + 1;

  logic [2:0] clk_s, dat_s, stb_s;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-2:0] setup_q;
  logic cal_owed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_s <= '0;
      dat_s <= '0;
      stb_s <= '0;
    end else begin
      clk_s <= {clk_s[1:0], ser_clk};
      dat_s <= {dat_s[1:0], ser_data};
      stb_s <= {stb_s[1:0], ser_strobe};
    end

  wire shift_edge = clk_s[1] & ~clk_s[2];
  wire commit     = stb_s[1] & ~stb_s[2];
  wire [3:0] addr = shreg[3:0];
  wire busy       = cal_reg[WORD_W-1];
  wire soft_clr   = commit && addr == 4'd0 && shreg[4];
  wire wr_setup   = commit && addr == 4'd0 && !shreg[4];
  wire wr_cal     = commit && addr == 4'd1 && !busy;
  wire wr_div     = commit && addr == 4'd2 && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (shift_edge) shreg <= {dat_s[1], shreg[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      setup_q  <= '0;
      cal_reg  <= '0;
      div_reg  <= '0;
      div_live <= '0;
      cal_owed <= 1'b1;
    end else begin
      if (cal_done && busy) cal_owed <= 1'b0;
      if (soft_clr) begin
        setup_q  <= '0;
        cal_reg  <= '0;
        div_reg  <= '0;
        div_live <= '0;
      end else begin
        if (wr_setup) setup_q <= shreg[WORD_W-2:0];
        if (wr_cal) cal_reg <= shreg;
        else if (cal_done) cal_reg[WORD_W-1] <= 1'b0;
        if (wr_div) div_reg <= shreg;
        else if (lock_ok) div_reg[29] <= 1'b0;
        if (div_reg[29]) div_live <= div_reg[LIVE_HI:LIVE_LO];
      end
    end

  assign setup_reg = {cal_owed, setup_q};
  assign buf_en = setup_q[10] ? buf_pin : ~setup_q[11];

  assert_cal_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && busy && !commit) |=> !cal_reg[WORD_W-1]);
  assert_div_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cal_done && !soft_clr) |=> $stable(div_reg[28:0]) && $stable(div_reg[31:30]));
  assert_lock_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ok && div_reg[29] && !commit) |=> !div_reg[29]);
  assert_soft_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (setup_reg[WORD_W-2:0] == '0 && cal_reg == '0 && div_reg == '0 && div_live == '0));
  assert_setup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(setup_reg[WORD_W-2:0]));
  assert_owed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_reg[WORD_W-1] |=> !setup_reg[WORD_W-1]);
  assert_live_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_reg[29] && !soft_clr) |=> $stable(div_live));
  initial assert (LIVE_W > 0);
endmodule

// File: tb/tb_serial_ctl_regs.sv
module tb_serial_ctl_regs;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_strobe = 0;
  logic cal_done = 0, lock_ok = 0, buf_pin = 0;
  logic [31:0] setup_reg, cal_reg, div_reg;
  logic [20:0] div_live;
  logic buf_en;
  int checks = 0, fails = 0;
  bit done = 0;

  serial_ctl_regs dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] w);
    for (int i = 0; i < 32; i++) begin
      ser_data = w[i]; cyc(4);
      ser_clk = 1; cyc(4);
      ser_clk = 0;
    end
    cyc(2);
    ser_strobe = 1; cyc(4);
    ser_strobe = 0; cyc(4);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
    cyc(1);
  endtask

  task automatic t_reset;
    chk("R10 setup", setup_reg, 32'h8000_0000);
    chk("R10 cal", cal_reg, 0);
    chk("R10 div", div_reg, 0);
    chk("R10 live", {11'b0, div_live}, 0);
    chk("R10 buf", {31'b0, buf_en}, 1);
  endtask

  task automatic t_setup;
    send(32'h1234_5AE0);
    chk("R1 setup word", setup_reg, 32'h9234_5AE0);
    chk("R8 bit11 off", {31'b0, buf_en}, 0);
    send(32'h0000_0400);
    buf_pin = 1; cyc(1);
    chk("R8 pin high", {31'b0, buf_en}, 1);
    buf_pin = 0; cyc(1);
    chk("R8 pin low", {31'b0, buf_en}, 0);
    send(32'h7FFF_F7E0);
    chk("R9 write no effect on bit31", setup_reg, 32'hFFFF_F7E0);
  endtask

  task automatic t_unused;
    send(32'hDEAD_BEE5);
    chk("R2 unused setup", setup_reg, 32'hFFFF_F7E0);
    chk("R2 unused cal", cal_reg, 0);
    chk("R2 unused div", div_reg, 0);
  endtask

  task automatic t_div;
    logic [31:0] w;
    send(32'h0ABC_DEF2);
    chk("R2 div word", div_reg, 32'h0ABC_DEF2);
    chk("R6 no load", {11'b0, div_live}, 0);
    w = 32'h2ABC_DEF2;
    send(w);
    chk("R6 loaded", {11'b0, div_live}, (w >> 4) & 32'h1F_FFFF);
    pulse(lock_ok);
    chk("R7 clear", div_reg, 32'h0ABC_DEF2);
    send(32'h0123_4562);
    chk("R6 held", {11'b0, div_live}, (w >> 4) & 32'h1F_FFFF);
    pulse(lock_ok);
    chk("R7 idle lock", div_reg, 32'h0123_4562);
  endtask

  task automatic t_cal;
    send(32'h8000_1231);
    chk("R4 busy set", cal_reg, 32'h8000_1231);
    send(32'h0000_0012);
    chk("R5 div blocked", div_reg, 32'h0123_4562);
    send(32'h0000_0001);
    chk("R5 cal blocked", cal_reg, 32'h8000_1231);
    send(32'h0000_0000);
    chk("R5 setup allowed", setup_reg, 32'h8000_0000);
    pulse(cal_done);
    chk("R4 cleared", cal_reg, 32'h0000_1231);
    chk("R9 owed cleared", setup_reg, 32'h0000_0000);
    send(32'h0000_0012);
    chk("R5 div after cal", div_reg, 32'h0000_0012);
  endtask

  task automatic t_soft;
    send(32'h2000_0072);
    send(32'h0000_0310);
    chk("R3 setup", setup_reg, 0);
    chk("R3 cal", cal_reg, 0);
    chk("R3 div", div_reg, 0);
    chk("R3 live", {11'b0, div_live}, 0);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset;
    t_setup;
    t_unused;
    t_div;
    t_cal;
    t_soft;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule